// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port memory of 32-bit words in four byte lanes. Every address, control and write-data input is registered on the rising clock edge, and read data passes through an output register, so the data for an address taken at one edge reaches the bus after the next edge. The shared data bus is modelled as a data-in vector, a data-out vector and a drive-enable output. A drive-enable high means the block owns the bus.

Either of two address strobes can open an access. The processor strobe (`pstrb_n`) always opens a read, and a write on that path lands one edge later. The controller strobe (`cstrb_n`) writes in the same edge it is sampled. Three chip enables qualify both strobes. A 2-bit burst sequencer steps the low address bits in linear or interleaved order. A sleep input moves the block through a state machine that ignores inputs while it sleeps and keeps the memory contents.

State machine: ST_IDLE (deselected, no burst), ST_BURST (burst open), ST_DOZE (sleep sampled once), ST_SLEEP and ST_WAKE (low power). Transitions are as follows. IDLE/BURST go to BURST on a selected strobe, to IDLE on a deselecting strobe, and to DOZE when sleep is high. DOZE goes to SLEEP if sleep is high, otherwise to IDLE. SLEEP stays in SLEEP while sleep is high, otherwise it goes to WAKE. WAKE goes to SLEEP if sleep is high, otherwise to IDLE.

Top module: `pburst_sram`

## Requirements
- R1: The block is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A strobe taken while the block is not selected is a deselect. A deselect writes nothing and closes the burst.
- R2: A read whose address is registered at edge k drives `dout`, with `dout_en`=1, from edge k+1 while `oe_n` is 0.
- R3: When `allwr_n`=0, a write stores all four bytes whatever `bytewr_n` and `bsel_n` hold.
- R4: When `allwr_n`=1 and `bytewr_n`=0, each byte whose `bsel_n` bit is 0 is written. Bit i covers `din[8i+7:8i]`. Other bytes keep their contents. With no byte chosen, the edge is a read.
- R5: A processor-strobe edge is always a read, and its write controls and data are ignored. A write on that path is committed at the following edge, using the controls and data present at that edge.
- R6: A controller-strobe write stores the data present at that same edge. When both strobes are low with `cs1_n`=0, the processor strobe wins. The processor strobe is ignored when `cs1_n`=1.
- R7: From the edge where a write is performed, `dout_en` is 0 regardless of `oe_n`. It stays 0 through later burst reads until a strobe opens a new read.
- R8: In the cycle after a read that starts from the deselected state, `dout_en` is 0 even with `oe_n`=0.
- R9: A deselect at an edge forces `dout_en` to 0 from that edge, even while read data is in flight.
- R10: `oe_n` acts without a clock: with read data held, `dout_en` follows `oe_n` at once.
- R11: On a burst edge without a strobe, `adv_n`=0 steps the 2-bit burst offset and `adv_n`=1 repeats the current address. With `order_lin`=1 the offset is start+n mod 4. With `order_lin`=0 it is start XOR n. Upper address bits stay fixed.
- R12: `lowpwr` rises after the second consecutive edge with `sleep`=1 and falls after the second edge with `sleep`=0. `dout_en` is 0 throughout, and memory contents are kept.
- R13: An access open when `sleep` is sampled high is dropped. Strobes applied while in low power are ignored.
- R14: After reset the block is deselected, and `dout_en` and `lowpwr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| cs1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| allwr_n | input | 1 | Write all bytes, active low |
| bytewr_n | input | 1 | Byte-write qualifier, active low |
| bsel_n | input | DATA_W/8 | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Low-power request, active high |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus |
| dout_en | output | 1 | Bus drive enable |
| lowpwr | output | 1 | Low-power state indication |

## Verification
The bench targets the following corner cases:
- A processor-strobe edge that carries write controls. A design that honoured them would overwrite data that the later read still shows unchanged.
- A burst read that continues after a write. A design that drove the bus again here would collide with the next writer.
- A deselect while read data is in flight, and a read that starts straight after a deselect. Driving in either case would expose stale data.
- Both burst orders from an odd start offset, where linear and interleaved sequences differ. A design that swapped or mis-wrapped them returns words out of order.
- Sleep entry and exit timing, a read left open at sleep entry, and a write strobe during sleep. A design that counted one edge too few, completed the open read, or accepted the strobe would show a wrong `lowpwr`, a driven bus or altered memory.

// File: rtl/pburst_sram_pkg.sv
package pburst_sram_pkg;

    // Width of the wrapping burst offset (four beats)
    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST,
        ST_DOZE,
        ST_SLEEP,
        ST_WAKE
    } pb_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } pb_op_e;

endpackage

// File: rtl/pburst_seq.sv
module pburst_seq #(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_base,
    input  logic             step,
    input  logic             linear,
    output logic [OFF_W-1:0] cur_off,
    output logic [OFF_W-1:0] next_off
);

    logic [OFF_W-1:0] base_q;
    logic [OFF_W-1:0] cnt_q;
    logic [OFF_W-1:0] cnt_inc;

    assign cnt_inc = OFF_W'(cnt_q + 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= load_base;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_inc;
        end
    end

    always_comb begin
        if (linear) begin
            cur_off  = OFF_W'(base_q + cnt_q);
            next_off = OFF_W'(base_q + cnt_inc);
        end else begin
            cur_off  = base_q ^ cnt_q;
            next_off = base_q ^ cnt_inc;
        end
    end

    // A freshly loaded burst starts at the captured offset
    assert_load_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_off == $past(load_base)));

endmodule

// File: rtl/pburst_array.sv
module pburst_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_mask[b]) begin
                lane_mem[wr_addr] <= wr_data[b*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                lane_q <= lane_mem[rd_addr];
            end
        end

        assign rd_data[b*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
    import pburst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  cs1_n,
    input  logic                  cs2,
    input  logic                  cs3_n,
    input  logic                  pstrb_n,
    input  logic                  cstrb_n,
    input  logic                  adv_n,
    input  logic                  allwr_n,
    input  logic                  bytewr_n,
    input  logic [DATA_W/8-1:0]   bsel_n,
    input  logic                  oe_n,
    input  logic                  sleep,
    input  logic                  order_lin,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     dout,
    output logic                  dout_en,
    output logic                  lowpwr
);

    localparam int LANES = DATA_W / 8;
    localparam int HI_W  = ADDR_W - BURST_W;

    pb_state_e state_q, state_d;
    pb_op_e    op;

    logic               sel, p_take, c_take, strobe, start, desel, awake;
    logic [LANES-1:0]   mask_in, arr_mask;
    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] cur_off, nxt_off;
    logic               seq_load, seq_step;
    logic [ADDR_W-1:0]  use_addr, paddr_q;
    logic               rd_ok_q, rd_ok_d, rd_issue, pend_q, drv_q;
    logic [DATA_W-1:0]  rd_data;

    // Edge decode: strobes, selection, write mask
    always_comb begin
        sel     = !cs1_n && cs2 && !cs3_n;
        p_take  = !pstrb_n && !cs1_n;
        c_take  = !cstrb_n && !p_take;
        strobe  = p_take || c_take;
        start   = strobe && sel;
        desel   = strobe && !sel;
        awake   = !sleep && (state_q == ST_IDLE || state_q == ST_BURST);
        mask_in = !allwr_n ? '1 : (!bytewr_n ? ~bsel_n : '0);
    end

    // Operation performed at this edge and the address it uses
    always_comb begin
        op       = OP_NONE;
        use_addr = addr;
        seq_load = 1'b0;
        seq_step = 1'b0;
        if (awake) begin
            if (start) begin
                seq_load = 1'b1;
                op = (p_take || mask_in == '0) ? OP_READ : OP_WRITE;
            end else if (!desel && state_q == ST_BURST) begin
                seq_step = !adv_n;
                use_addr = {hi_q, (adv_n ? cur_off : nxt_off)};
                op = (mask_in != '0) ? OP_WRITE : OP_READ;
            end
        end
        arr_mask = (op == OP_WRITE) ? mask_in : '0;
    end

    // Read permission: opened by a strobe read, closed by a write
    always_comb begin
        rd_ok_d = rd_ok_q;
        if (!awake || desel) begin
            rd_ok_d = 1'b0;
        end else if (op == OP_READ && start) begin
            rd_ok_d = 1'b1;
        end else if (op == OP_WRITE) begin
            rd_ok_d = 1'b0;
        end
        rd_issue = (op == OP_READ) && rd_ok_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BURST: begin
                if (sleep)      state_d = ST_DOZE;
                else if (start) state_d = ST_BURST;
                else if (desel) state_d = ST_IDLE;
            end
            ST_DOZE:  state_d = sleep ? ST_SLEEP : ST_IDLE;
            ST_SLEEP: state_d = sleep ? ST_SLEEP : ST_WAKE;
            ST_WAKE:  state_d = sleep ? ST_SLEEP : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pipeline registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ok_q <= 1'b0;
            pend_q  <= 1'b0;
            drv_q   <= 1'b0;
            paddr_q <= '0;
            hi_q    <= '0;
        end else begin
            rd_ok_q <= rd_ok_d;
            pend_q  <= rd_issue;
            drv_q   <= pend_q && awake && (op != OP_WRITE) && !desel;
            paddr_q <= use_addr;
            if (seq_load) hi_q <= addr[ADDR_W-1:BURST_W];
        end
    end

    pburst_seq #(.OFF_W(BURST_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq_load),
        .load_base (addr[BURST_W-1:0]),
        .step      (seq_step),
        .linear    (order_lin),
        .cur_off   (cur_off),
        .next_off  (nxt_off)
    );

    pburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(8)) array_i (
        .clk     (clk),
        .wr_mask (arr_mask),
        .wr_addr (use_addr),
        .wr_data (din),
        .rd_en   (pend_q),
        .rd_addr (paddr_q),
        .rd_data (rd_data)
    );

    // Output process
    always_comb begin
        dout    = rd_data;
        dout_en = drv_q && !oe_n;
        lowpwr  = (state_q == ST_SLEEP) || (state_q == ST_WAKE);
    end

    assert_write_tristate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !dout_en);

    assert_deselect_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && desel) |=> !dout_en);

    assert_first_cycle_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && awake && start) |=> !dout_en);

    assert_sleep_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr |-> !dout_en);

    assert_sleep_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lowpwr) |-> $past(sleep));

    assert_sleep_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lowpwr) |-> !$past(sleep));

endmodule

// File: tb/pburst_sram_tb_top.sv
module pburst_sram_tb_top;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NB = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] addr = '0;
    logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
    logic allwr_n = 1'b1, bytewr_n = 1'b1, oe_n = 1'b0;
    logic sleep = 1'b0, order_lin = 1'b1;
    logic [NB-1:0] bsel_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en, lowpwr;

    pburst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .allwr_n(allwr_n),
        .bytewr_n(bytewr_n), .bsel_n(bsel_n), .oe_n(oe_n), .sleep(sleep),
        .order_lin(order_lin), .din(din), .dout(dout), .dout_en(dout_en), .lowpwr(lowpwr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    int m_state = 0;
    logic [1:0] m_base = '0, m_cnt = '0;
    logic [AW-3:0] m_hi = '0;
    bit m_rdok = 0, m_pend = 0, m_drv = 0;
    logic [AW-1:0] m_paddr = '0;
    logic [DW-1:0] m_data;

    function automatic logic [1:0] burst_off(input logic [1:0] b, input logic [1:0] c, input logic lin);
        return lin ? 2'(b + c) : (b ^ c);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit pv, cv, st, ds, sel, aw;
        logic [NB-1:0] bm;
        int op;
        logic [AW-1:0] a;
        op = 0;
        a = addr;
        sel = !cs1_n && cs2 && !cs3_n;
        pv = !pstrb_n && !cs1_n;
        cv = !cstrb_n && !pv;
        st = (pv || cv) && sel;
        ds = (pv || cv) && !sel;
        bm = !allwr_n ? '1 : (!bytewr_n ? ~bsel_n : '0);
        aw = !sleep && (m_state < 2);
        if (aw && st) begin
            op = (pv || bm == 0) ? 1 : 2;
            m_base = addr[1:0];
            m_cnt = '0;
            m_hi = addr[AW-1:2];
            m_rdok = (op == 1);
        end else if (aw && !ds && m_state == 1) begin
            if (!adv_n) m_cnt = 2'(m_cnt + 1);
            a = {m_hi, burst_off(m_base, m_cnt, order_lin)};
            op = (bm != 0) ? 2 : 1;
            if (op == 2) m_rdok = 0;
        end else if (!aw || ds) begin
            m_rdok = 0;
        end
        m_drv = m_pend && aw && (op != 2) && !ds;
        if (m_pend) m_data = ref_mem[m_paddr];
        m_pend = (op == 1) && m_rdok;
        m_paddr = a;
        if (op == 2) begin
            for (int b = 0; b < NB; b++) begin
                if (bm[b]) ref_mem[a][b*8 +: 8] = din[b*8 +: 8];
            end
        end
        if (m_state < 2) begin
            if (sleep) m_state = 2;
            else if (st) m_state = 1;
            else if (ds) m_state = 0;
        end else if (m_state == 2) m_state = sleep ? 3 : 0;
        else if (m_state == 3) m_state = sleep ? 3 : 4;
        else m_state = sleep ? 3 : 0;
    endtask

    // One clock: model the edge, then compare ports mid-cycle
    task automatic step();
        @(posedge clk);
        if (rst_n) model_edge();
        #5;
        chk("R12 lowpwr", {31'b0, lowpwr}, {31'b0, (m_state == 3 || m_state == 4)});
        chk("R7 R9 drive", {31'b0, dout_en}, {31'b0, (m_drv && !oe_n)});
        if (dout_en && m_drv && !$isunknown(m_data)) chk("R2 data", dout, m_data);
    endtask

    task automatic idle();
        cs1_n = 0; cs2 = 1; cs3_n = 0;
        pstrb_n = 1; cstrb_n = 1; adv_n = 1;
        allwr_n = 1; bytewr_n = 1; bsel_n = '1;
    endtask

    task automatic cwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cstrb_n = 0; allwr_n = 0; addr = a; din = d;
        step();
        idle();
    endtask

    task automatic deselect();
        cstrb_n = 0; cs2 = 0;
        step();
        idle();
    endtask

    task automatic pread(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag, input bit from_idle);
        pstrb_n = 0; addr = a;
        step();
        if (from_idle) chk("R8 first cycle hi-z", {31'b0, dout_en}, 32'd0);
        idle();
        step();
        chk(tag, {31'b0, dout_en}, 32'd1);
        chk(tag, dout, exp);
    endtask

    localparam logic [DW-1:0] VA = 32'hA1B2C3D4, VB = 32'h11223344, VC = 32'h5A5A0F0F;
    localparam logic [DW-1:0] VD1 = 32'hDEAD0001, VD0 = 32'hBAD00000;
    localparam logic [DW-1:0] W0 = 32'h0000F000, W1 = 32'h1111F001, W2 = 32'h2222F002, W3 = 32'h3333F003;

    initial begin
        void'($urandom(32'h5EED1234));
        idle();
        step(); step();
        // R14: reset state
        chk("R14 dout_en", {31'b0, dout_en}, 32'd0);
        chk("R14 lowpwr", {31'b0, lowpwr}, 32'd0);
        #5 rst_n = 1;
        step();

        // R2, R8, R10
        cwrite(5, VA);
        deselect();
        pread(5, VA, "R2 read latency", 1);
        oe_n = 1; #1;
        chk("R10 oe off", {31'b0, dout_en}, 32'd0);
        oe_n = 0; #1;
        chk("R10 oe on", {31'b0, dout_en}, 32'd1);

        // R4: bytes 0 and 2 selected
        cstrb_n = 0; bytewr_n = 0; bsel_n = 4'b1010; addr = 5; din = VB;
        step(); idle();
        pread(5, {VA[31:24], VB[23:16], VA[15:8], VB[7:0]}, "R4 byte write", 0);

        // R3: global write overrides byte selects
        cstrb_n = 0; allwr_n = 0; bytewr_n = 0; bsel_n = 4'b1110; addr = 5; din = VC;
        step(); idle();
        pread(5, VC, "R3 global write", 0);

        // R5: processor-path write lands on the second edge
        pstrb_n = 0; allwr_n = 0; addr = 7; din = VD0;
        step(); idle();
        allwr_n = 0; din = VD1;
        step();
        chk("R7 write hi-z", {31'b0, dout_en}, 32'd0);
        idle();
        step();
        chk("R7 stays hi-z", {31'b0, dout_en}, 32'd0);
        deselect();
        pread(7, VD1, "R5 second-edge write", 1);

        // R5: write controls on the strobe edge are ignored
        pstrb_n = 0; allwr_n = 0; addr = 7; din = VD0;
        step(); idle();
        deselect();
        pread(7, VD1, "R5 first edge ignored", 1);

        // R6: processor strobe wins over controller strobe
        pstrb_n = 0; cstrb_n = 0; allwr_n = 0; addr = 7; din = VD0;
        step(); idle();
        deselect();
        pread(7, VD1, "R6 priority", 1);

        // R6: processor strobe ignored with cs1_n high
        pstrb_n = 0; cs1_n = 1; addr = 9;
        step();
        chk("R6 pstrb ignored", {31'b0, dout_en}, 32'd1);
        chk("R6 pstrb ignored data", dout, VD1);
        idle();

        // R1 and R9: controller write with cs3_n high is a deselect
        cstrb_n = 0; cs3_n = 1; allwr_n = 0; addr = 7; din = VD0;
        step();
        chk("R9 deselect hi-z", {31'b0, dout_en}, 32'd0);
        idle();
        pread(7, VD1, "R1 no write when unselected", 1);

        // R11: bursts from offset 1
        cwrite(8, W0); cwrite(9, W1); cwrite(10, W2); cwrite(11, W3);
        order_lin = 1; pstrb_n = 0; addr = 9;
        step(); idle(); adv_n = 0;
        step(); chk("R11 linear beat0", dout, W1);
        step(); chk("R11 linear beat1", dout, W2);
        step(); chk("R11 linear beat2", dout, W3);
        adv_n = 1;
        step(); chk("R11 linear wrap hold", dout, W0);
        order_lin = 0; pstrb_n = 0; addr = 9;
        step(); idle(); adv_n = 0;
        step(); chk("R11 interleave beat0", dout, W1);
        step(); chk("R11 interleave beat1", dout, W0);
        step(); chk("R11 interleave beat2", dout, W3);
        adv_n = 1;
        step(); chk("R11 interleave hold", dout, W2);
        order_lin = 1;

        // R12: sleep entry and exit timing, contents kept
        deselect();
        sleep = 1;
        step(); chk("R12 entry edge1", {31'b0, lowpwr}, 32'd0);
        step(); chk("R12 entry edge2", {31'b0, lowpwr}, 32'd1);
        step();
        sleep = 0;
        step(); chk("R12 exit edge1", {31'b0, lowpwr}, 32'd1);
        step(); chk("R12 exit edge2", {31'b0, lowpwr}, 32'd0);
        pread(8, W0, "R12 contents kept", 1);

        // R13: open read dropped, strobes ignored while asleep
        pstrb_n = 0; addr = 10;
        step(); idle();
        sleep = 1;
        step(); chk("R13 pending dropped", {31'b0, dout_en}, 32'd0);
        step();
        cstrb_n = 0; allwr_n = 0; addr = 8; din = VD0;
        step(); idle();
        sleep = 0;
        step(); step();
        pread(8, W0, "R13 strobe ignored asleep", 1);

        // Constrained random traffic against the model
        for (int i = 0; i < 400; i++) begin
            addr = AW'($urandom_range(0, 15));
            if ($urandom_range(0, 99) < 85) {cs1_n, cs2, cs3_n} = 3'b010;
            else {cs1_n, cs2, cs3_n} = 3'($urandom());
            pstrb_n = ($urandom_range(0, 99) >= 20);
            cstrb_n = ($urandom_range(0, 99) >= 20);
            adv_n = 1'($urandom());
            allwr_n = ($urandom_range(0, 99) >= 15);
            bytewr_n = ($urandom_range(0, 99) >= 30);
            bsel_n = 4'($urandom());
            oe_n = ($urandom_range(0, 99) >= 80);
            order_lin = 1'($urandom());
            din = $urandom();
            step();
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule